// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits between a processor's instruction fetch port and a slow main memory. The processor asks for one 32-bit instruction word at a time. The block keeps two groups of four consecutive words. The current group answers requests. The second group holds the next four addresses and is fetched ahead of need. One memory access always moves a whole group as a single 128-bit beat.

On a miss, the block fetches the aligned group that holds the requested word and passes that word on as soon as the beat lands. It keeps the other three words. Once a group is current, the block asks for the following group on its own. When the instruction stream walks into that group, the prefetched group becomes current and the next one is requested. A jump to any other address throws both groups away and starts a fresh fill. A flush input clears both groups after a redirect. Two counters report hits and misses.

Top module: `ifs_prefetch_buf`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `cpu_rsp_valid` and `mem_req` are low, `cpu_req_ready` is high and both counters read zero.
- R2: A request outside both held groups is a miss. It increments `miss_count` and causes exactly one memory access whose address is the request address with bits [1:0] cleared. The response word is lane `addr[1:0]` of the beat, where lane i is `mem_rsp_data[32*i+31:32*i]`.
- R3: A request inside the current group is answered with `cpu_rsp_valid` high in the cycle after it is accepted. It increments `hit_count` and leaves `miss_count` unchanged.
- R4: Once a group is current and no memory access is outstanding, the block requests the next group (group base plus four, wrapping from the top of the address space to zero) without any processor request.
- R5: A request into a prefetched group whose beat has already arrived makes that group current and is answered in the next cycle as a hit.
- R6: A request into a prefetched group whose beat has not yet arrived waits for that beat. It issues no further memory access and counts as a hit.
- R7: At most one memory access is outstanding at any time. A response belonging to a discarded prefetch is dropped and never reaches the processor.
- R8: `flush` is taken in a cycle where the block is idle. It drops `cpu_req_ready` for that cycle and invalidates both groups, so the next request to a previously held word is a miss.
- R9: `cpu_req_ready` is low while a fill or a prefetch wait is in progress, and only one processor request is in service at a time.
- R10: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until a cycle in which `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate both groups |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block accepts a request this cycle |
| cpu_req_addr | input | 32 | Word address of the requested instruction |
| cpu_rsp_valid | output | 1 | One-cycle pulse: response word valid |
| cpu_rsp_data | output | 32 | Instruction word |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Group base address (bits [1:0] zero) |
| mem_rsp_valid | input | 1 | Beat returned by memory |
| mem_rsp_data | input | 128 | Four words, lane i at bits 32*i+31:32*i |
| hit_count | output | 32 | Number of requests served without their own fill |
| miss_count | output | 32 | Number of requests that started a fill |

## Verification
The hardest case to reach from the ports is a prefetch that is still in flight when the speculation is abandoned. Its beat then has to be dropped, and the fresh fill must serve data from a separate access. The bench reaches this case by watching the memory model until the prefetch handshake has completed. It then changes the data its memory model returns for new accesses and pulses flush before the stale beat comes back. A block that forwarded the stale beat would return words from the old data set. The pending-prefetch hit of R6 is timed the same way: the memory latency is longer than a run of sequential hits, so the walk into the next group arrives before its beat does.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  // controller phases
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FILL_REQ  = 2'd1,
    ST_FILL_WAIT = 2'd2,
    ST_WAIT_PF   = 2'd3
  } ifs_state_e;

  // state of the speculative (next) group
  typedef enum logic [1:0] {
    PF_NONE  = 2'd0,
    PF_PEND  = 2'd1,
    PF_READY = 2'd2
  } ifs_pf_e;

endpackage

// File: rtl/ifs_mem_port.sv
module ifs_mem_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid
);

  logic          req_q;
  logic          wait_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      req_q  <= 1'b1;
      addr_q <= start_addr;
    end else if (req_q && mem_gnt) begin
      req_q  <= 1'b0;
      wait_q <= 1'b1;
    end else if (wait_q && mem_rsp_valid) begin
      wait_q <= 1'b0;
    end
  end

  assign busy     = req_q | wait_q;
  assign done     = wait_q & mem_rsp_valid;
  assign mem_req  = req_q;
  assign mem_addr = addr_q;

  // R10: request held with a stable address until granted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R7: a new access is only started while nothing is outstanding
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R7: requesting and awaiting a beat never overlap
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !wait_q);

endmodule

// File: rtl/ifs_group_store.sv
module ifs_group_store #(
  parameter int DW  = 32,
  parameter int WPG = 4,
  parameter int NB  = 2
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [$clog2(NB)-1:0]  wsel,
  input  logic [DW*WPG-1:0]      wdata,
  input  logic [$clog2(NB)-1:0]  rsel,
  input  logic [$clog2(WPG)-1:0] rofs,
  output logic [DW-1:0]          rword
);

  localparam int LW = DW * WPG;

  logic [LW-1:0] bank_q [NB];
  logic [LW-1:0] line;
  logic [DW-1:0] lanes [WPG];

  always_ff @(posedge clk) begin
    if (we) bank_q[wsel] <= wdata;
  end

  assign line = bank_q[rsel];

  for (genvar g = 0; g < WPG; g++) begin : g_lane
    assign lanes[g] = line[g*DW +: DW];
  end

  assign rword = lanes[rofs];

endmodule

// File: rtl/ifs_event_counter.sv
module ifs_event_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + W'(1);
  end

endmodule

// File: rtl/ifs_prefetch_buf.sv
module ifs_prefetch_buf
  import ifs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WPG   = 4,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [AW-1:0]     cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic [DW-1:0]     cpu_rsp_data,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW*WPG-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  localparam int OW  = $clog2(WPG);
  localparam int GIW = AW - OW;

  ifs_state_e     st_q;
  ifs_pf_e        pf_q;
  logic           cur_valid_q;
  logic           cur_sel_q;
  logic           drop_q;
  logic           inflight_pf_q;
  logic [GIW-1:0] cur_grp_q;
  logic [GIW-1:0] miss_grp_q;
  logic [OW-1:0]  miss_ofs_q;

  logic [GIW-1:0] req_grp;
  logic [OW-1:0]  req_ofs;
  logic [GIW-1:0] pf_grp;
  logic           accept, in_cur, in_pf;
  logic           hit_now, promote_now, waitpf_now, miss_now;
  logic           fill_start, pf_start, port_start;
  logic [AW-1:0]  port_addr;
  logic           port_busy, port_done, good_done;
  logic           st_we, st_wsel, st_rsel;
  logic [OW-1:0]  st_rofs;
  logic [DW-1:0]  st_word, byp_word;

  assign req_grp = cpu_req_addr[AW-1:OW];
  assign req_ofs = cpu_req_addr[OW-1:0];
  assign pf_grp  = cur_grp_q + GIW'(1);

  assign cpu_req_ready = (st_q == ST_IDLE) && !flush;
  assign accept        = cpu_req_valid && cpu_req_ready;

  assign in_cur = cur_valid_q && (req_grp == cur_grp_q);
  assign in_pf  = cur_valid_q && (pf_q != PF_NONE) && (req_grp == pf_grp);

  assign hit_now     = accept && in_cur;
  assign promote_now = accept && !in_cur && in_pf && (pf_q == PF_READY);
  assign waitpf_now  = accept && !in_cur && in_pf && (pf_q == PF_PEND);
  assign miss_now    = accept && !in_cur && !in_pf;

  assign fill_start = (st_q == ST_FILL_REQ) && !port_busy;
  assign pf_start   = (st_q == ST_IDLE) && cur_valid_q && (pf_q == PF_NONE)
                      && !port_busy && !flush && !miss_now;
  assign port_start = fill_start | pf_start;
  assign port_addr  = {(fill_start ? miss_grp_q : pf_grp), {OW{1'b0}}};

  assign good_done = port_done && !drop_q;

  // storage: fills go to the current bank, prefetches to the other one
  assign st_we   = good_done && (inflight_pf_q || (st_q == ST_FILL_WAIT));
  assign st_wsel = inflight_pf_q ? ~cur_sel_q : cur_sel_q;
  assign st_rsel = ((st_q == ST_WAIT_PF) || !in_cur) ? ~cur_sel_q : cur_sel_q;
  assign st_rofs = (st_q == ST_WAIT_PF) ? miss_ofs_q : req_ofs;

  assign byp_word = mem_rsp_data[miss_ofs_q*DW +: DW];

  ifs_mem_port #(.AW(AW)) u_port (
    .clk           (clk),
    .rst           (rst),
    .start         (port_start),
    .start_addr    (port_addr),
    .busy          (port_busy),
    .done          (port_done),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid)
  );

  ifs_group_store #(.DW(DW), .WPG(WPG), .NB(2)) u_store (
    .clk   (clk),
    .we    (st_we),
    .wsel  (st_wsel),
    .wdata (mem_rsp_data),
    .rsel  (st_rsel),
    .rofs  (st_rofs),
    .rword (st_word)
  );

  ifs_event_counter #(.W(CNT_W)) u_hits (
    .clk   (clk),
    .rst   (rst),
    .inc   (hit_now | promote_now | waitpf_now),
    .count (hit_count)
  );

  ifs_event_counter #(.W(CNT_W)) u_misses (
    .clk   (clk),
    .rst   (rst),
    .inc   (miss_now),
    .count (miss_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      pf_q          <= PF_NONE;
      cur_valid_q   <= 1'b0;
      cur_sel_q     <= 1'b0;
      drop_q        <= 1'b0;
      inflight_pf_q <= 1'b0;
      cur_grp_q     <= '0;
      miss_grp_q    <= '0;
      miss_ofs_q    <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;

      if (port_start) inflight_pf_q <= pf_start;

      // a beat still owed to an abandoned access must be dropped
      if (port_done)
        drop_q <= 1'b0;
      else if ((miss_now || ((st_q == ST_IDLE) && flush)) && port_busy)
        drop_q <= 1'b1;

      if (pf_start) pf_q <= PF_PEND;
      if (good_done && inflight_pf_q && (pf_q == PF_PEND)) pf_q <= PF_READY;

      unique case (st_q)
        ST_IDLE: begin
          if (flush) begin
            cur_valid_q <= 1'b0;
            pf_q        <= PF_NONE;
          end else if (hit_now) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= st_word;
          end else if (promote_now) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= st_word;
            cur_sel_q     <= ~cur_sel_q;
            cur_grp_q     <= pf_grp;
            pf_q          <= PF_NONE;
          end else if (waitpf_now) begin
            miss_ofs_q <= req_ofs;
            st_q       <= ST_WAIT_PF;
          end else if (miss_now) begin
            cur_valid_q <= 1'b0;
            pf_q        <= PF_NONE;
            miss_grp_q  <= req_grp;
            miss_ofs_q  <= req_ofs;
            st_q        <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: begin
          if (fill_start) st_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (good_done) begin
            cur_valid_q   <= 1'b1;
            cur_grp_q     <= miss_grp_q;
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= byp_word;
            st_q          <= ST_IDLE;
          end
        end
        ST_WAIT_PF: begin
          if (good_done || (pf_q == PF_READY)) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_data  <= good_done ? byp_word : st_word;
            cur_sel_q     <= ~cur_sel_q;
            cur_grp_q     <= pf_grp;
            pf_q          <= PF_NONE;
            st_q          <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a current-group hit answers in the next cycle
  assert_hit_next_R3: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> cpu_rsp_valid);

  // R5: a promoted group answers in the next cycle and counts as a hit
  assert_promote_next_R5: assert property (@(posedge clk) disable iff (rst)
    promote_now |=> (cpu_rsp_valid && (hit_count != $past(hit_count))));

  // R2: the miss counter only moves after an accepted miss
  assert_miss_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (miss_count != $past(miss_count)) |-> $past(miss_now));

  // R2: memory addresses are group aligned
  assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OW-1:0] == '0));

  // R9: no new request is taken while one is in service
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> !cpu_req_ready);

endmodule

// File: tb/ifs_prefetch_buf_tb.sv
module ifs_prefetch_buf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 10;
  localparam int WDOG       = 100000;
  localparam int NV         = 16;

  // kind: 0 = immediate hit, 1 = hit that waits for a prefetch, 2 = miss
  localparam logic [31:0] VEC_ADDR [NV] = '{
    32'h100, 32'h101, 32'h102, 32'h103, 32'h104, 32'h105, 32'h108, 32'h10A,
    32'h200, 32'h201, 32'h1FF, 32'h1FC, 32'h200, 32'h204, 32'h007, 32'h004};
  localparam int VEC_KIND [NV] = '{2, 0, 0, 0, 1, 0, 0, 0, 2, 0, 2, 0, 0, 1, 2, 0};
  localparam int VEC_GAP  [NV] = '{0, 0, 0, 0, 0, 0, 30, 0, 0, 0, 30, 0, 30, 0, 30, 0};

  logic         clk, rst, flush;
  logic         cpu_req_valid, cpu_req_ready;
  logic [31:0]  cpu_req_addr;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rsp_data;
  logic         mem_req, mem_gnt;
  logic [31:0]  mem_addr;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_data;
  logic [31:0]  hit_count, miss_count;

  int checks = 0;
  int errors = 0;

  // memory model state
  int          outstanding = 0;
  int          cnt = 0;
  int          grants = 0;
  int          overlap_err = 0, hold_err = 0, hold_events = 0, align_err = 0;
  logic [31:0] hs_addr = '0, last_hs = '0;
  logic [7:0]  epoch = 8'd0, hs_epoch = 8'd0;
  logic        prev_req = 1'b0, prev_gnt = 1'b0;
  logic [31:0] prev_addr = '0;

  ifs_prefetch_buf u_dut (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_data  (cpu_rsp_data),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .hit_count     (hit_count),
    .miss_count    (miss_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mword(input logic [31:0] a, input logic [7:0] ep);
    return a ^ {ep, 8'hA5, 16'h3C00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // memory: grant on alternate cycles, beat LAT cycles after the handshake
  initial begin
    mem_gnt = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        outstanding = 0;
        mem_rsp_valid = 1'b0;
        prev_req = 1'b0;
      end else begin
        if (prev_req && !prev_gnt) begin
          hold_events++;
          if (!mem_req || mem_addr != prev_addr) hold_err++;
        end
        if (mem_rsp_valid) begin
          mem_rsp_valid = 1'b0;
          outstanding = 0;
        end else if (outstanding != 0 && cnt > 0) begin
          cnt--;
          if (cnt == 0) begin
            mem_rsp_valid = 1'b1;
            for (int i = 0; i < 4; i++)
              mem_rsp_data[i*32 +: 32] = mword(hs_addr + 32'(i), hs_epoch);
          end
        end
        mem_gnt = ~mem_gnt;
        if (mem_req && mem_gnt) begin
          if (outstanding != 0) overlap_err++;
          if (mem_addr[1:0] != 2'b00) align_err++;
          outstanding = 1;
          cnt = LAT;
          hs_addr = mem_addr;
          hs_epoch = epoch;
          last_hs = mem_addr;
          grants++;
        end
        prev_req = mem_req;
        prev_gnt = mem_gnt;
        prev_addr = mem_addr;
      end
    end
  end

  task automatic do_req(input logic [31:0] a, input int kind, input int gap,
                        input string tag);
    int h0, m0, g0, cyc, guard;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    h0 = hit_count;
    m0 = miss_count;
    g0 = grants;
    cpu_req_valid = 1'b1;
    cpu_req_addr = a;
    #1;
    guard = 0;
    while (!cpu_req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cyc = 1;
    while (!cpu_rsp_valid && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(cpu_rsp_valid && cpu_rsp_data == mword(a, epoch), {tag, " data"},
          cpu_rsp_data, mword(a, epoch));
    if (kind == 2) begin
      check(miss_count == m0 + 1, {tag, " miss count R2"}, miss_count, m0 + 1);
      check(hit_count == h0, {tag, " hit count R2"}, hit_count, h0);
      check(grants > g0, {tag, " fill issued R2"}, grants, g0 + 1);
    end else begin
      check(hit_count == h0 + 1, {tag, " hit count R3"}, hit_count, h0 + 1);
      check(miss_count == m0, {tag, " miss count R3"}, miss_count, m0);
      if (kind == 0)
        check(cyc == 1, {tag, " next-cycle answer R3/R5"}, cyc, 1);
      else
        check(grants - g0 <= 1, {tag, " no extra access R6"}, grants - g0, 1);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    flush = 1'b0;
    cpu_req_valid = 1'b0;
    cpu_req_addr = '0;
    repeat (4) @(negedge clk);
    check(!cpu_rsp_valid && !mem_req, "R1 outputs idle in reset", {cpu_rsp_valid, mem_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_req_ready, "R1 ready after reset", cpu_req_ready, 1);
    check(!cpu_rsp_valid, "R1 no response", cpu_rsp_valid, 0);
    check(!mem_req, "R1 no memory request", mem_req, 0);
    check(hit_count == 0 && miss_count == 0, "R1 counters zero", hit_count | miss_count, 0);

    // table walk: sequential stream, prefetch wait, promotion, jumps
    for (int v = 0; v < NV; v++)
      do_req(VEC_ADDR[v], VEC_KIND[v], VEC_GAP[v], $sformatf("vec%0d", v));

    // top of the address space wraps into group zero (R4)
    do_req(32'hFFFF_FFFE, 2, 30, "wrap miss R2");
    do_req(32'hFFFF_FFFF, 0, 0, "wrap hit R3");
    do_req(32'h0000_0000, 0, 30, "wrap promote R4 R5");
    do_req(32'h0000_0001, 0, 0, "after wrap R3");

    // flush invalidates both groups (R8) after the next group was fetched (R4)
    do_req(32'h300, 2, 30, "pre-flush fill R2");
    repeat (30) @(negedge clk);
    check(last_hs == 32'h304, "R4 next group requested", last_hs, 32'h304);
    flush = 1'b1;
    #1;
    check(!cpu_req_ready, "R8 ready low during flush", cpu_req_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    do_req(32'h301, 2, 0, "R8 flushed word misses");

    // stale prefetch beat must be dropped (R7)
    do_req(32'h400, 2, 30, "stale setup R2");
    do_req(32'h401, 0, 0, "stale setup R3");
    begin
      int guard;
      guard = 0;
      while (outstanding == 0 && guard < 100) begin
        @(negedge clk);
        guard++;
      end
    end
    check(outstanding != 0 && last_hs == 32'h404, "R4 prefetch in flight", last_hs, 32'h404);
    epoch = epoch + 8'd1;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_req(32'h406, 2, 0, "R7 stale beat dropped");
    do_req(32'h404, 0, 0, "R7 fresh group kept");

    repeat (30) @(negedge clk);
    check(overlap_err == 0, "R7 single access in flight", overlap_err, 0);
    check(hold_events > 0 && hold_err == 0, "R10 request held until grant", hold_err, 0);
    check(align_err == 0, "R2 aligned memory addresses", align_err, 0);

    summary();
    $finish;
  end

endmodule